// File: doc/BRIEF.md
# Audio/DSP Control and Interrupt Register

This block is a single 16-bit control and status word that sits between a host CPU and an audio DSP subsystem. It gathers three interrupt sources: audio DMA completion, auxiliary-memory DMA completion, and a DSP-to-CPU request. Each source has a sticky status bit, set by a hardware event pulse and cleared when software writes a one to it. Each source also has a read/write mask bit. The block drives one combined interrupt line to the CPU.

The same word gives software three controls over the DSP: a self-clearing reset, a halt and a CPU-to-DSP interrupt request. It also shows a read-only DSP-DMA-busy flag and an initialisation handshake pair. Software clears the handshake request bit and then polls the acknowledge bit until it reads zero; the acknowledge bit follows the request after a fixed settling delay.

The host side is a plain register port: a write strobe, a read strobe, a byte address and a 16-bit data word. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or status level, and event inputs are one-cycle pulses.

Top module: `dspctl_reg`

## Requirements
- R1: After reset the word reads 0x0C00: bits 11 and 10 are 1 and every other stored bit is 0. The pins `dsp_reset`, `dsp_halt`, `dsp_irq_req` and `cpu_irq` are 0.
- R2: Writing 1 to bit 0 raises `dsp_reset`, and bit 0 reads 1, for exactly RST_CYC clock cycles after the write edge; then both clear by themselves. A write of 1 during the run restarts it. Writing 0 to bit 0 has no effect.
- R3: Bit 1 is a read/write bit driving `dsp_irq_req`. Bit 2 is a read/write bit driving `dsp_halt`.
- R4: Status bits 3 (audio DMA, `ev_audio_dma`), 5 (auxiliary DMA, `ev_aux_dma`) and 7 (DSP request, `ev_dsp_irq`) are set by their event pulse. Each stays set until software writes a 1 to that bit. Writing 0 to a status bit leaves it unchanged.
- R5: When an event pulse and a write-1-clear hit the same status bit in the same cycle, the bit ends up set.
- R6: Bits 4, 6 and 8 are read/write mask bits for the status bits 3, 5 and 7 respectively.
- R7: `cpu_irq` is 1 exactly when at least one status bit and its mask bit are both 1.
- R8: Bit 9 reads the current level of `dsp_dma_busy`, and writes do not affect it.
- R9: Bit 11 is read/write and resets to 1. Bit 10 is read-only and shows the value bit 11 held SETTLE_CYC clock edges earlier. Bit 10 resets to 1.
- R10: Bits 15:12 read 0. `rdata` is 0 unless `rd_en` is 1 and `addr` equals REG_ADDR. A write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | ADDR_W | Host byte address |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Host read data (combinational) |
| ev_audio_dma | input | 1 | Audio DMA completion pulse |
| ev_aux_dma | input | 1 | Auxiliary-memory DMA completion pulse |
| ev_dsp_irq | input | 1 | DSP-to-CPU request pulse |
| dsp_dma_busy | input | 1 | DSP DMA transfer in progress |
| dsp_reset | output | 1 | Reset to the DSP core |
| dsp_halt | output | 1 | Halt to the DSP core |
| dsp_irq_req | output | 1 | CPU-to-DSP interrupt request |
| cpu_irq | output | 1 | Combined interrupt to the CPU |

## Verification
The bench builds the block with its defaults: ADDR_W=4, REG_ADDR=0xA, RST_CYC=4 and SETTLE_CYC=2. The short reset run and settling delay let every cycle of both windows be checked one by one. With three sources there are only 64 status/mask pairs, so the bench sweeps all of them and computes the expected word and interrupt level from the bit positions.

// File: rtl/dspctl_pkg.sv
package dspctl_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned NSRC     = 3;
  localparam int unsigned POS_RST  = 0;
  localparam int unsigned POS_DINT = 1;
  localparam int unsigned POS_HALT = 2;
  localparam int unsigned POS_BUSY = 9;
  localparam int unsigned POS_ACK  = 10;
  localparam int unsigned POS_REQ  = 11;

  typedef enum logic [1:0] {
    SRC_AUDIO = 2'd0,
    SRC_AUX   = 2'd1,
    SRC_DSP   = 2'd2
  } src_e;

  function automatic int unsigned stat_pos(input int unsigned src);
    return 3 + 2 * src;
  endfunction

  function automatic int unsigned mask_pos(input int unsigned src);
    return 4 + 2 * src;
  endfunction
endpackage

// File: rtl/irq_slice.sv
module irq_slice (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_hit,
  input  logic mask_we,
  input  logic mask_d,
  output logic stat_q,
  output logic mask_q,
  output logic req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      stat_q <= set_evt | (stat_q & ~clr_hit);
      if (mask_we) mask_q <= mask_d;
    end
  end

  assign req = stat_q & mask_q;
endmodule

// File: rtl/reset_timer.sv
module reset_timer #(
  parameter int unsigned RST_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int unsigned CNT_W = $clog2(RST_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(RST_CYC);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                 left_q <= '0;
    else if (start)             left_q <= LOAD;
    else if (left_q != '0)      left_q <= left_q - 1'b1;
  end

  assign active = (left_q != '0);
endmodule

// File: rtl/settle_pipe.sv
module settle_pipe #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic [DEPTH-1:0] st_q;
      always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '1;
        else if (DEPTH == 1) st_q <= d;
        else st_q <= {st_q[DEPTH-2:0], d};
      end
      assign q = st_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/dspctl_reg.sv
module dspctl_reg
  import dspctl_pkg::*;
#(
  parameter int unsigned        ADDR_W     = 4,
  parameter logic [ADDR_W-1:0]  REG_ADDR   = 4'hA,
  parameter int unsigned        RST_CYC    = 4,
  parameter int unsigned        SETTLE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  input  logic              ev_audio_dma,
  input  logic              ev_aux_dma,
  input  logic              ev_dsp_irq,
  input  logic              dsp_dma_busy,
  output logic              dsp_reset,
  output logic              dsp_halt,
  output logic              dsp_irq_req,
  output logic              cpu_irq
);
  logic            hit, reg_we;
  logic [NSRC-1:0] evt, stat_v, mask_v, req_v;
  logic            dint_q, halt_q, req_bit_q, ack_bit;
  logic            unused_wbits;

  assign hit    = (addr == REG_ADDR);
  assign reg_we = wr_en & hit;

  always_comb begin
    evt           = '0;
    evt[SRC_AUDIO] = ev_audio_dma;
    evt[SRC_AUX]   = ev_aux_dma;
    evt[SRC_DSP]   = ev_dsp_irq;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_src
      irq_slice u_slice (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (evt[gi]),
        .clr_hit (reg_we & wdata[stat_pos(gi)]),
        .mask_we (reg_we),
        .mask_d  (wdata[mask_pos(gi)]),
        .stat_q  (stat_v[gi]),
        .mask_q  (mask_v[gi]),
        .req     (req_v[gi])
      );
    end
  endgenerate

  reset_timer #(.RST_CYC(RST_CYC)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (reg_we & wdata[POS_RST]),
    .active (dsp_reset)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dint_q    <= 1'b0;
      halt_q    <= 1'b0;
      req_bit_q <= 1'b1;
    end else if (reg_we) begin
      dint_q    <= wdata[POS_DINT];
      halt_q    <= wdata[POS_HALT];
      req_bit_q <= wdata[POS_REQ];
    end
  end

  settle_pipe #(.DEPTH(SETTLE_CYC)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (req_bit_q),
    .q     (ack_bit)
  );

  assign dsp_halt    = halt_q;
  assign dsp_irq_req = dint_q;
  assign cpu_irq     = |req_v;

  always_comb begin
    rdata = '0;
    if (rd_en && hit) begin
      rdata[POS_RST]  = dsp_reset;
      rdata[POS_DINT] = dint_q;
      rdata[POS_HALT] = halt_q;
      for (int i = 0; i < NSRC; i++) begin
        rdata[stat_pos(i)] = stat_v[i];
        rdata[mask_pos(i)] = mask_v[i];
      end
      rdata[POS_BUSY] = dsp_dma_busy;
      rdata[POS_ACK]  = ack_bit;
      rdata[POS_REQ]  = req_bit_q;
    end
  end

  assign unused_wbits = ^{wdata[15:12], wdata[POS_ACK], wdata[POS_BUSY]};
endmodule

// File: rtl/dspctl_reg_chk.sv
module dspctl_reg_chk #(
  parameter int unsigned       ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'hA,
  parameter int unsigned       RST_CYC  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [15:0]       wdata,
  input logic [15:0]       rdata,
  input logic [2:0]        evt,
  input logic [2:0]        stat_v,
  input logic              dsp_dma_busy,
  input logic              dsp_reset
);
  logic wr_hit, rd_hit;
  logic [2:0] clr_bits;
  int unsigned run_cnt;

  assign wr_hit   = wr_en && (addr == REG_ADDR);
  assign rd_hit   = rd_en && (addr == REG_ADDR);
  assign clr_bits = {wdata[7], wdata[5], wdata[3]};

  always_ff @(posedge clk) begin
    if (!rst_n)                     run_cnt <= 0;
    else if (wr_hit && wdata[0])    run_cnt <= 0;
    else if (dsp_reset)             run_cnt <= run_cnt + 1;
    else                            run_cnt <= 0;
  end

  // R2: reset run starts on the next cycle and never outlasts RST_CYC
  a_r2_reset_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wdata[0]) |=> dsp_reset);
  a_r2_reset_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= RST_CYC);

  // R5: an event always leaves its status bit set
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((stat_v & $past(evt)) == $past(evt)));

  // R4: a set status bit only falls through a write of 1 to it
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_hit) |=> ((stat_v & $past(stat_v)) == $past(stat_v)));
  a_r4_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && clr_bits == 3'b000) |=> ((stat_v & $past(stat_v)) == $past(stat_v)));

  // R8: busy flag reads back the live input
  a_r8_busy_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> (rdata[9] == dsp_dma_busy));

  // R10: upper bits and unselected reads are zero
  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[15:12] == 4'h0);
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> (rdata == 16'h0));
endmodule

bind dspctl_reg dspctl_reg_chk #(
  .ADDR_W   (ADDR_W),
  .REG_ADDR (REG_ADDR),
  .RST_CYC  (RST_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .rd_en        (rd_en),
  .addr         (addr),
  .wdata        (wdata),
  .rdata        (rdata),
  .evt          (evt),
  .stat_v       (stat_v),
  .dsp_dma_busy (dsp_dma_busy),
  .dsp_reset    (dsp_reset)
);

// File: tb/tb_dspctl_reg.sv
module tb_dspctl_reg;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] RADDR = 4'hA;
  localparam int RSTC = 4;
  localparam int SETC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic ev_audio_dma = 1'b0, ev_aux_dma = 1'b0, ev_dsp_irq = 1'b0;
  logic dsp_dma_busy = 1'b0;
  logic dsp_reset, dsp_halt, dsp_irq_req, cpu_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dspctl_reg #(.ADDR_W(4), .REG_ADDR(RADDR), .RST_CYC(RSTC), .SETTLE_CYC(SETC)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ev_audio_dma(ev_audio_dma),
    .ev_aux_dma(ev_aux_dma), .ev_dsp_irq(ev_dsp_irq), .dsp_dma_busy(dsp_dma_busy),
    .dsp_reset(dsp_reset), .dsp_halt(dsp_halt), .dsp_irq_req(dsp_irq_req),
    .cpu_irq(cpu_irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, let the edge take it, release at next negedge
  task automatic cyc(input logic we, input logic [3:0] a, input logic [15:0] d,
                     input logic [2:0] ev);
    wr_en = we; addr = a; wdata = d;
    ev_audio_dma = ev[0]; ev_aux_dma = ev[1]; ev_dsp_irq = ev[2];
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wdata = 16'h0;
    ev_audio_dma = 1'b0; ev_aux_dma = 1'b0; ev_dsp_irq = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    rd_en = 1'b0;
  endtask

  function automatic logic [15:0] spread(input logic [2:0] s, input int base);
    logic [15:0] r = '0;
    for (int i = 0; i < 3; i++) r[base + 2*i] = s[i];
    return r;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(RADDR, v); chk("R1 word", v, 16'h0C00);
    chk("R1 pins", {12'h0, dsp_reset, dsp_halt, dsp_irq_req, cpu_irq}, 16'h0);

    // R10 read gating and foreign addresses
    addr = RADDR; rd_en = 1'b0; #1 chk("R10 rd_en low", rdata, 16'h0);
    rd(4'h2, v); chk("R10 other addr read", v, 16'h0);
    cyc(1'b1, 4'h2, 16'h0806, 3'b000);
    chk("R10 other addr write", {14'h0, dsp_halt, dsp_irq_req}, 16'h0);

    // R3 control bits
    cyc(1'b1, RADDR, 16'h0806, 3'b000);
    chk("R3 pins set", {14'h0, dsp_halt, dsp_irq_req}, 16'h3);
    rd(RADDR, v); chk("R3 readback", v, 16'h0C06);
    cyc(1'b1, RADDR, 16'h0804, 3'b000);
    chk("R3 dint clear", {14'h0, dsp_halt, dsp_irq_req}, 16'h2);
    cyc(1'b1, RADDR, 16'h0800, 3'b000);
    chk("R3 halt clear", {14'h0, dsp_halt, dsp_irq_req}, 16'h0);

    // R8 busy flag
    dsp_dma_busy = 1'b1;
    rd(RADDR, v); chk("R8 busy 1", {15'h0, v[9]}, 16'h1);
    cyc(1'b1, RADDR, 16'h0800, 3'b000);
    rd(RADDR, v); chk("R8 write ignored", {15'h0, v[9]}, 16'h1);
    dsp_dma_busy = 1'b0;
    rd(RADDR, v); chk("R8 busy 0", {15'h0, v[9]}, 16'h0);

    // R2 self-clearing reset
    cyc(1'b1, RADDR, 16'h0801, 3'b000);
    for (int i = 0; i < RSTC + 2; i++) begin
      rd(RADDR, v);
      chk($sformatf("R2 cycle %0d pin", i), {15'h0, dsp_reset}, (i < RSTC) ? 16'h1 : 16'h0);
      chk($sformatf("R2 cycle %0d bit", i), {15'h0, v[0]}, (i < RSTC) ? 16'h1 : 16'h0);
      @(negedge clk);
    end
    cyc(1'b1, RADDR, 16'h0801, 3'b000);
    @(negedge clk); @(negedge clk);
    cyc(1'b1, RADDR, 16'h0801, 3'b000);
    for (int i = 0; i < RSTC + 1; i++) begin
      chk($sformatf("R2 restart %0d", i), {15'h0, dsp_reset}, (i < RSTC) ? 16'h1 : 16'h0);
      @(negedge clk);
    end
    cyc(1'b1, RADDR, 16'h0800, 3'b000);
    chk("R2 zero write", {15'h0, dsp_reset}, 16'h0);

    // R4 R6 R7 sweep over every mask and status pattern
    for (int m = 0; m < 8; m++) begin
      for (int s = 0; s < 8; s++) begin
        logic [15:0] mb, sb;
        mb = spread(3'(m), 4);
        sb = spread(3'(s), 3);
        cyc(1'b1, RADDR, 16'h08A8 | mb, 3'b000);
        cyc(1'b0, RADDR, 16'h0000, 3'(s));
        rd(RADDR, v);
        chk($sformatf("R4 R6 word m=%0d s=%0d", m, s), v, 16'h0C00 | mb | sb);
        chk($sformatf("R7 irq m=%0d s=%0d", m, s), {15'h0, cpu_irq},
            {15'h0, |(3'(m) & 3'(s))});
        cyc(1'b1, RADDR, 16'h0800 | mb, 3'b000);
        rd(RADDR, v);
        chk($sformatf("R4 zero write m=%0d s=%0d", m, s), v, 16'h0C00 | mb | sb);
      end
    end

    // R5 set beats clear; R4 single-bit clear
    cyc(1'b1, RADDR, 16'h08A8, 3'b000);
    cyc(1'b1, RADDR, 16'h08A8, 3'b111);
    rd(RADDR, v); chk("R5 set wins", v & 16'h00A8, 16'h00A8);
    cyc(1'b1, RADDR, 16'h0820, 3'b000);
    rd(RADDR, v); chk("R4 clear aux only", v & 16'h00A8, 16'h0088);
    cyc(1'b1, RADDR, 16'h0888, 3'b000);
    rd(RADDR, v); chk("R4 clear rest", v & 16'h00A8, 16'h0000);

    // R9 handshake settle
    cyc(1'b1, RADDR, 16'h0000, 3'b000);
    for (int i = 0; i < SETC + 2; i++) begin
      rd(RADDR, v);
      chk($sformatf("R9 fall %0d", i), {14'h0, v[11:10]},
          (i < SETC) ? 16'h1 : 16'h0);
      @(negedge clk);
    end
    cyc(1'b1, RADDR, 16'h0C00, 3'b000);
    for (int i = 0; i < SETC + 1; i++) begin
      rd(RADDR, v);
      chk($sformatf("R9 rise %0d", i), {14'h0, v[11:10]},
          (i < SETC) ? 16'h2 : 16'h3);
      @(negedge clk);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule